// File: doc/BRIEF.md
# Dispatch Group Hazard Checker

This block follows how a dispatch group fills, one candidate instruction at a time. A group holds up to five slots. Each execution unit class has its own occupancy limit within the group. The scheduler presents a candidate as a unit class code and two flags: one marks a write to the counter register, the other marks a branch through that counter. A third input bit comes from a separate address comparator and says whether a load overlaps a location being stored.

The block answers within the same cycle with a verdict:
- no hazard;
- hazard, meaning the candidate would end the group;
- no-op required, meaning the candidate would cause a costly replay unless a no-op comes first.

Three strobes move the group state forward. One issues the candidate, one inserts a no-op, and one starts a basic block. The verdict depends only on the registered group state and the candidate inputs.

Top module: `dgrp_hazard_chk`

## Requirements
- R1: Verdict codes on `verdict_o` are 0 for no hazard, 1 for hazard and 2 for no-op required. A group has five slots. Once the fifth slot is used by an issue or a no-op, all group state clears, so any candidate then sees an empty group.
- R2: Class codes are 1 for fixed-point, 2 for load, 3 for store and 4 for floating-point. A group takes at most two fixed-point, two floating-point and two load/store operations, where loads and stores share the same limit. A candidate of a class already at its limit gets verdict 1.
- R3: Class codes are 5 for condition-register, 6 for vector ALU and 7 for vector permute. Each of these classes allows one operation per group, and a second one gets verdict 1. A class checks only its own limit, so a full class does not block a different class.
- R4: Class code 8 is branch. With four slots filled, every non-branch candidate gets verdict 1 and a branch candidate gets verdict 0.
- R5: Issuing a branch closes the group at once, and all counts and flags clear.
- R6: After an issue that has `cand_ctr_wr_i` set, a branch candidate with `cand_ctr_br_i` set gets verdict 2 until the group closes. A branch without that flag gets verdict 0.
- R7: A load candidate with `cand_ld_ovl_i` set gets verdict 2 only if a store has issued in the current group. The overlap bit has no effect when no store has issued, and it has no effect on non-load classes.
- R8: A no-op strobe uses one slot and charges no unit limit.
- R9: Class code 0 is pseudo. A pseudo candidate always gets verdict 0, and issuing it changes no state, even with `cand_ctr_wr_i` set.
- R10: `bb_start_i` clears all group state. It takes priority over an issue or a no-op in the same cycle, and that issue or no-op has no effect.
- R11: When a candidate meets both a hazard condition and a no-op condition, the verdict is 1.
- R12: Issuing a candidate whose verdict is 1 closes the current group. That candidate then becomes the first entry of a new group.
- R13: When `issue_i` and `noop_i` are high in the same cycle, only the issue takes effect. Synchronous reset clears all group state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cand_cls_i | input | 4 | Unit class code of the candidate |
| cand_ctr_wr_i | input | 1 | Candidate writes the counter register |
| cand_ctr_br_i | input | 1 | Candidate branches through the counter register |
| cand_ld_ovl_i | input | 1 | Candidate load overlaps a stored address (from the comparator) |
| issue_i | input | 1 | Issue the candidate into the group |
| noop_i | input | 1 | Insert a no-op into the group |
| bb_start_i | input | 1 | Start of a basic block; clears the group |
| verdict_o | output | 2 | Verdict for the current candidate |

## Verification
The hardest case to reach from the ports is a candidate that is both blocked by a full unit and flagged for a no-op. To reach it, the stimulus issues a store and then a load, which fills the shared load/store limit and also sets the store-seen flag. A third load is then presented with the overlap bit set.

Closing a group cannot be seen directly, because no port shows it. Each test therefore first fills a class up to its limit. It then closes the group by a branch, by the fifth slot, or by an issue that carried a hazard verdict. A later probe of that class shows whether the count was cleared.

Strobe collisions are tested by sequences whose final verdict differs depending on whether the lower-priority strobe was counted:
- a basic-block start together with an issue;
- an issue together with a no-op.

// File: rtl/dgh_pkg.sv
package dgh_pkg;

    localparam int unsigned GROUP_SLOTS = 5;
    localparam int unsigned FXU_LIMIT   = 2;
    localparam int unsigned LSU_LIMIT   = 2;
    localparam int unsigned FPU_LIMIT   = 2;

    localparam int unsigned MAX_LIMIT = (FXU_LIMIT > LSU_LIMIT) ?
                                        ((FXU_LIMIT > FPU_LIMIT) ? FXU_LIMIT : FPU_LIMIT) :
                                        ((LSU_LIMIT > FPU_LIMIT) ? LSU_LIMIT : FPU_LIMIT);
    localparam int unsigned CNT_W  = $clog2(MAX_LIMIT + 1);
    localparam int unsigned SLOT_W = $clog2(GROUP_SLOTS);
    localparam int unsigned CLS_W  = 4;
    localparam int unsigned VERD_W = 2;

    typedef enum logic [CLS_W-1:0] {
        CLS_PSEUDO = 4'd0,
        CLS_FXU    = 4'd1,
        CLS_LOAD   = 4'd2,
        CLS_STORE  = 4'd3,
        CLS_FPU    = 4'd4,
        CLS_CR     = 4'd5,
        CLS_VALU   = 4'd6,
        CLS_VPERM  = 4'd7,
        CLS_BRANCH = 4'd8
    } unit_cls_e;

    typedef enum logic [VERD_W-1:0] {
        VERD_NONE   = 2'd0,
        VERD_HAZARD = 2'd1,
        VERD_NOOP   = 2'd2
    } verdict_e;

    typedef struct packed {
        logic [CNT_W-1:0] fxu;
        logic [CNT_W-1:0] lsu;
        logic [CNT_W-1:0] fpu;
        logic             cr;
        logic             valu;
        logic             vperm;
    } unit_occ_t;

    function automatic logic unit_full(unit_occ_t o, unit_cls_e c);
        case (c)
            CLS_FXU:             return o.fxu == CNT_W'(FXU_LIMIT);
            CLS_LOAD, CLS_STORE: return o.lsu == CNT_W'(LSU_LIMIT);
            CLS_FPU:             return o.fpu == CNT_W'(FPU_LIMIT);
            CLS_CR:              return o.cr;
            CLS_VALU:            return o.valu;
            CLS_VPERM:           return o.vperm;
            default:             return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/dgh_slot_ctr.sv
module dgh_slot_ctr
    import dgh_pkg::*;
#(
    parameter int unsigned SLOTS = GROUP_SLOTS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      bb_start,
    input  logic                      do_issue,
    input  logic                      is_branch,
    input  logic                      restart,
    input  logic                      do_noop,
    output logic [$clog2(SLOTS)-1:0]  slot_cnt,
    output logic                      last_slot,
    output logic                      clr_after
);
    localparam int unsigned SW   = $clog2(SLOTS);
    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic [SW-1:0] base;
    logic [SW-1:0] slot_n;

    assign last_slot = (slot_cnt == LAST);

    always_comb begin
        base      = restart ? '0 : slot_cnt;
        slot_n    = slot_cnt;
        clr_after = 1'b0;
        if (do_issue) begin
            if (is_branch || base == LAST) begin
                clr_after = 1'b1;
                slot_n    = '0;
            end else begin
                slot_n = base + SW'(1);
            end
        end else if (do_noop) begin
            if (slot_cnt == LAST) begin
                clr_after = 1'b1;
                slot_n    = '0;
            end else begin
                slot_n = slot_cnt + SW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bb_start) slot_cnt <= '0;
        else                 slot_cnt <= slot_n;
    end

    // R1
    slot_range_chk: assert property (@(posedge clk) disable iff (rst)
        slot_cnt < SW'(SLOTS));

endmodule

// File: rtl/dgh_unit_occ.sv
module dgh_unit_occ
    import dgh_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      bb_start,
    input  logic      clr_before,
    input  logic      clr_after,
    input  logic      apply,
    input  unit_cls_e cls,
    input  logic      ctr_wr,
    output unit_occ_t occ,
    output logic      ctr_set,
    output logic      store_seen
);
    unit_occ_t occ_n;
    logic      ctr_n;
    logic      st_n;

    always_comb begin
        occ_n = clr_before ? '0 : occ;
        ctr_n = clr_before ? 1'b0 : ctr_set;
        st_n  = clr_before ? 1'b0 : store_seen;
        if (apply) begin
            case (cls)
                CLS_FXU:             occ_n.fxu = occ_n.fxu + CNT_W'(1);
                CLS_LOAD, CLS_STORE: occ_n.lsu = occ_n.lsu + CNT_W'(1);
                CLS_FPU:             occ_n.fpu = occ_n.fpu + CNT_W'(1);
                CLS_CR:              occ_n.cr    = 1'b1;
                CLS_VALU:            occ_n.valu  = 1'b1;
                CLS_VPERM:           occ_n.vperm = 1'b1;
                default: ;
            endcase
            if (ctr_wr)             ctr_n = 1'b1;
            if (cls == CLS_STORE)   st_n  = 1'b1;
        end
        if (clr_after) begin
            occ_n = '0;
            ctr_n = 1'b0;
            st_n  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || bb_start) begin
            occ        <= '0;
            ctr_set    <= 1'b0;
            store_seen <= 1'b0;
        end else begin
            occ        <= occ_n;
            ctr_set    <= ctr_n;
            store_seen <= st_n;
        end
    end

    // R2
    occ_limit_chk: assert property (@(posedge clk) disable iff (rst)
        occ.fxu <= CNT_W'(FXU_LIMIT) && occ.lsu <= CNT_W'(LSU_LIMIT) &&
        occ.fpu <= CNT_W'(FPU_LIMIT));

endmodule

// File: rtl/dgh_verdict.sv
module dgh_verdict
    import dgh_pkg::*;
(
    input  unit_cls_e cls,
    input  unit_occ_t occ,
    input  logic      last_slot,
    input  logic      ctr_set,
    input  logic      store_seen,
    input  logic      ctr_br,
    input  logic      ld_ovl,
    output logic      hazard,
    output verdict_e  verdict
);
    logic noop_req;

    always_comb begin
        hazard   = (cls != CLS_PSEUDO) &&
                   (unit_full(occ, cls) || (last_slot && cls != CLS_BRANCH));
        noop_req = (cls == CLS_BRANCH && ctr_br && ctr_set) ||
                   (cls == CLS_LOAD && ld_ovl && store_seen);
        if (hazard)        verdict = VERD_HAZARD;
        else if (noop_req) verdict = VERD_NOOP;
        else               verdict = VERD_NONE;
    end

endmodule

// File: rtl/dgrp_hazard_chk.sv
module dgrp_hazard_chk
    import dgh_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [CLS_W-1:0]      cand_cls_i,
    input  logic                  cand_ctr_wr_i,
    input  logic                  cand_ctr_br_i,
    input  logic                  cand_ld_ovl_i,
    input  logic                  issue_i,
    input  logic                  noop_i,
    input  logic                  bb_start_i,
    output logic [VERD_W-1:0]     verdict_o
);
    unit_cls_e             cls;
    unit_occ_t             occ;
    logic [SLOT_W-1:0]     slot_cnt;
    logic                  last_slot;
    logic                  clr_after;
    logic                  ctr_set;
    logic                  store_seen;
    logic                  hazard;
    logic                  do_issue;
    logic                  restart;
    verdict_e              verdict;

    assign cls       = unit_cls_e'(cand_cls_i);
    assign do_issue  = issue_i && (cls != CLS_PSEUDO);
    assign restart   = do_issue && hazard;
    assign verdict_o = verdict;

    dgh_slot_ctr #(.SLOTS(GROUP_SLOTS)) slot_i (
        .clk       (clk),
        .rst       (rst),
        .bb_start  (bb_start_i),
        .do_issue  (do_issue),
        .is_branch (cls == CLS_BRANCH),
        .restart   (restart),
        .do_noop   (noop_i),
        .slot_cnt  (slot_cnt),
        .last_slot (last_slot),
        .clr_after (clr_after)
    );

    dgh_unit_occ occ_i (
        .clk        (clk),
        .rst        (rst),
        .bb_start   (bb_start_i),
        .clr_before (restart),
        .clr_after  (clr_after),
        .apply      (do_issue),
        .cls        (cls),
        .ctr_wr     (cand_ctr_wr_i),
        .occ        (occ),
        .ctr_set    (ctr_set),
        .store_seen (store_seen)
    );

    dgh_verdict verd_i (
        .cls        (cls),
        .occ        (occ),
        .last_slot  (last_slot),
        .ctr_set    (ctr_set),
        .store_seen (store_seen),
        .ctr_br     (cand_ctr_br_i),
        .ld_ovl     (cand_ld_ovl_i),
        .hazard     (hazard),
        .verdict    (verdict)
    );

    // R9
    pseudo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_i && cand_cls_i == CLS_PSEUDO && !noop_i && !bb_start_i) |=>
            ($stable(slot_cnt) && $stable(occ) && $stable(ctr_set)));

    // R5
    branch_close_chk: assert property (@(posedge clk) disable iff (rst)
        (issue_i && cand_cls_i == CLS_BRANCH) |=>
            (slot_cnt == '0 && occ == '0 && !ctr_set && !store_seen));

    // R10
    bb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        bb_start_i |=> (slot_cnt == '0 && occ == '0 && !ctr_set && !store_seen));

    // R8
    noop_no_charge_chk: assert property (@(posedge clk) disable iff (rst)
        (noop_i && !issue_i && !bb_start_i) |=> ($stable(occ) || occ == '0));

endmodule

// File: tb/dgrp_hazard_chk_tb_top.sv
`timescale 1ns/1ps
module dgrp_hazard_chk_tb_top;

    localparam logic [3:0] C_PS = 4'd0, C_FX = 4'd1, C_LD = 4'd2, C_ST = 4'd3,
                           C_FP = 4'd4, C_CR = 4'd5, C_VA = 4'd6, C_VP = 4'd7,
                           C_BR = 4'd8;
    localparam logic [1:0] V_OK = 2'd0, V_HZ = 2'd1, V_NP = 2'd2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] cls = C_PS;
    logic       ctr_wr = 1'b0, ctr_br = 1'b0, ovl = 1'b0;
    logic       issue = 1'b0, noop = 1'b0, bb = 1'b0;
    logic [1:0] verdict;
    int         tests = 0;
    int         fails = 0;
    logic       wd_hit = 1'b0;

    always #4 clk = ~clk;

    dgrp_hazard_chk dut_i (
        .clk(clk), .rst(rst), .cand_cls_i(cls), .cand_ctr_wr_i(ctr_wr),
        .cand_ctr_br_i(ctr_br), .cand_ld_ovl_i(ovl), .issue_i(issue),
        .noop_i(noop), .bb_start_i(bb), .verdict_o(verdict)
    );

    task automatic idle_inputs();
        cls = C_PS; ctr_wr = 0; ctr_br = 0; ovl = 0; issue = 0; noop = 0; bb = 0;
    endtask

    task automatic probe(input logic [3:0] c, input logic br, input logic ov,
                         input logic [1:0] exp, input string tag);
        @(negedge clk);
        cls = c; ctr_br = br; ovl = ov;
        #1;
        tests++;
        if (verdict !== exp) begin
            fails++;
            $display("FAIL %s: verdict=%0d expected=%0d", tag, verdict, exp);
        end
        idle_inputs();
    endtask

    task automatic pulse(input logic [3:0] c, input logic w, input logic is,
                         input logic np, input logic b);
        @(negedge clk);
        cls = c; ctr_wr = w; issue = is; noop = np; bb = b;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic iss(input logic [3:0] c);
        pulse(c, 1'b0, 1'b1, 1'b0, 1'b0);
    endtask

    task automatic new_block();
        pulse(C_PS, 1'b0, 1'b0, 1'b0, 1'b1);
    endtask

    task automatic ins_noop();
        pulse(C_PS, 1'b0, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_reset();
        probe(C_FX, 0, 0, V_OK, "R13 reset empty fxu");
        probe(C_CR, 0, 0, V_OK, "R13 reset empty cr");
    endtask

    task automatic t_fxu_fpu();
        new_block();
        iss(C_FX); iss(C_FX);
        probe(C_FX, 0, 0, V_HZ, "R2 third fxu");
        probe(C_FP, 0, 0, V_OK, "R3 fpu not blocked by fxu");
        probe(C_LD, 0, 0, V_OK, "R3 load not blocked by fxu");
        new_block();
        iss(C_FP); iss(C_FP);
        probe(C_FP, 0, 0, V_HZ, "R2 third fpu");
    endtask

    task automatic t_lsu_shared();
        new_block();
        iss(C_LD); iss(C_ST);
        probe(C_LD, 0, 0, V_HZ, "R2 load after ld+st");
        probe(C_ST, 0, 0, V_HZ, "R2 store after ld+st");
        probe(C_FX, 0, 0, V_OK, "R3 fxu free with lsu full");
    endtask

    task automatic t_single_units();
        new_block();
        iss(C_CR); iss(C_VA); iss(C_VP);
        probe(C_CR, 0, 0, V_HZ, "R3 second cr");
        probe(C_VA, 0, 0, V_HZ, "R3 second valu");
        probe(C_VP, 0, 0, V_HZ, "R3 second vperm");
        probe(C_FX, 0, 0, V_OK, "R3 fxu at slot four");
    endtask

    task automatic t_fifth_and_branch();
        new_block();
        iss(C_FX); iss(C_FP); iss(C_LD); iss(C_CR);
        probe(C_FP, 0, 0, V_HZ, "R4 non-branch in fifth slot");
        probe(C_BR, 0, 0, V_OK, "R4 branch in fifth slot");
        iss(C_BR);
        probe(C_CR, 0, 0, V_OK, "R5 cr clear after branch");
        new_block();
        iss(C_FX); iss(C_FX); iss(C_BR);
        probe(C_FX, 0, 0, V_OK, "R5 fxu clear after early branch");
    endtask

    task automatic t_noop_slots();
        new_block();
        iss(C_FX); iss(C_FX);
        ins_noop(); ins_noop(); ins_noop();
        probe(C_FX, 0, 0, V_OK, "R1 group closed after five slots");
        new_block();
        ins_noop(); ins_noop();
        probe(C_FX, 0, 0, V_OK, "R8 noop charges no fxu");
        ins_noop(); ins_noop();
        probe(C_FX, 0, 0, V_HZ, "R8 four noops fill four slots");
        probe(C_BR, 0, 0, V_OK, "R8 branch allowed after four noops");
    endtask

    task automatic t_ctr();
        new_block();
        pulse(C_FX, 1'b1, 1'b1, 1'b0, 1'b0);
        probe(C_BR, 1, 0, V_NP, "R6 ctr branch after ctr write");
        probe(C_BR, 0, 0, V_OK, "R6 plain branch after ctr write");
        iss(C_BR);
        probe(C_BR, 1, 0, V_OK, "R6 ctr flag cleared at close");
    endtask

    task automatic t_overlap();
        new_block();
        probe(C_LD, 0, 1, V_OK, "R7 overlap without store");
        iss(C_ST);
        probe(C_LD, 0, 1, V_NP, "R7 overlapping load after store");
        probe(C_LD, 0, 0, V_OK, "R7 non-overlapping load");
        probe(C_FX, 0, 1, V_OK, "R7 overlap bit on fxu");
        iss(C_LD);
        probe(C_LD, 0, 1, V_HZ, "R11 hazard over noop");
    endtask

    task automatic t_pseudo();
        new_block();
        iss(C_FX); iss(C_FX);
        probe(C_PS, 0, 0, V_OK, "R9 pseudo verdict");
        pulse(C_PS, 1'b1, 1'b1, 1'b0, 1'b0);
        pulse(C_PS, 1'b1, 1'b1, 1'b0, 1'b0);
        pulse(C_PS, 1'b1, 1'b1, 1'b0, 1'b0);
        probe(C_FX, 0, 0, V_HZ, "R9 pseudo issue kept state");
        probe(C_BR, 1, 0, V_OK, "R9 pseudo ctr write ignored");
    endtask

    task automatic t_bb_priority();
        new_block();
        pulse(C_FX, 1'b1, 1'b1, 1'b0, 1'b0);
        iss(C_FX);
        pulse(C_FX, 1'b0, 1'b1, 1'b0, 1'b1);
        iss(C_FX);
        probe(C_FX, 0, 0, V_OK, "R10 issue with bb ignored");
        probe(C_BR, 1, 0, V_OK, "R10 ctr flag cleared by bb");
    endtask

    task automatic t_restart();
        new_block();
        iss(C_FX); iss(C_FX);
        iss(C_FX);
        probe(C_FX, 0, 0, V_OK, "R12 hazard issue starts new group");
        iss(C_FX);
        probe(C_FX, 0, 0, V_HZ, "R12 candidate counted in new group");
    endtask

    task automatic t_issue_noop();
        new_block();
        pulse(C_CR, 1'b0, 1'b1, 1'b1, 1'b0);
        pulse(C_VA, 1'b0, 1'b1, 1'b1, 1'b0);
        probe(C_FP, 0, 0, V_OK, "R13 noop ignored with issue");
        probe(C_CR, 0, 0, V_HZ, "R13 issue taken with noop");
    endtask

    task automatic run_all();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_fxu_fpu();
        t_lsu_shared();
        t_single_units();
        t_fifth_and_branch();
        t_noop_slots();
        t_ctr();
        t_overlap();
        t_pseudo();
        t_bb_priority();
        t_restart();
        t_issue_noop();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (20000) @(posedge clk);
                wd_hit = 1'b1;
            end
        join_any
        disable fork;
        if (wd_hit) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule